// File: doc/BRIEF.md
# Flash Program/Erase Status Controller

This block models the write state machine of a flash array as seen through its 8-bit status register. It takes one decoded command per cycle: program, block erase, erase suspend, erase resume, program suspend, program resume, clear status, and a strobe that reports an invalid command sequence. Each command carries a target block index. A per-block lock vector, a supply-OK level and a verify-pass input, which stands in for the cell array, decide how an operation ends.

A program stays busy for a fixed number of cycles. An erase runs in pulses of a fixed length, up to a maximum pulse count, and stops at the first pulse whose verify passes. A suspend freezes the remaining time. The matching resume continues from that point. Error flags are sticky: they are set by failed verifies, a low supply, locked targets or sequence errors, and only a clear-status command removes them. Software polls `status_o`, waits for the ready bit, and then reads the error bits.

Top module: `flash_wsm_status`

## Requirements
- R1: After reset, `status_o` reads 0x80. Bit positions: 7 ready (1) or busy (0), 6 erase suspended, 5 erase error, 4 program error, 3 supply low, 2 program suspended, 1 locked-block violation, 0 reserved.
- R2: Bit 0 of `status_o` is always 0.
- R3: A program (code 1) accepted while idle clears bit 7 in the next cycle. Bit 7 stays 0 for exactly PROG_CYCLES cycles, after which the block returns to ready. A pass raises no error bit.
- R4: If `verify_pass_i` is low in the final program cycle, bit 4 is set when the block returns to ready.
- R5: A block erase (code 2) applies pulses of PULSE_CYCLES cycles and checks verify at the end of each pulse. If pulse k passes, the erase is busy for k*PULSE_CYCLES cycles. If all MAX_PULSES pulses fail, bit 5 is set after MAX_PULSES*PULSE_CYCLES cycles.
- R6: `supply_ok_i` is sampled only when a program or erase is accepted and in the final cycle of the verify step. A low sample at acceptance sets bit 3 and the block stays ready. A low sample at verify sets bit 3 and aborts to ready. Low levels between these two points have no effect.
- R7: A program or erase whose block has its `block_lock_i` bit set sets bit 1 and the block stays ready. This check takes priority over the supply check, so bit 3 is not set in that case.
- R8: Erase suspend (code 3) during an erase sets bits 7 and 6 in the next cycle. Bit 6 stays set until erase resume (code 4). After the resume, the remaining busy time is exactly what was left when the suspend was accepted.
- R9: Program suspend (code 5) during a program sets bits 7 and 2. Bit 2 stays set until program resume (code 6). After the resume, the remaining busy time continues from where it stopped.
- R10: A sequence-error strobe (code 8) while idle sets bits 5 and 4 while bit 7 reads 1 (status 0xB0 from a clean state).
- R11: Bits 5, 4, 3 and 1 are sticky. A new operation does not clear them. Clear status (code 7) clears them when idle or suspended and is ignored while busy.
- R12: A command that does not apply in the current state is ignored: program or erase while busy or suspended, a suspend of the wrong kind or while idle, and a resume that matches no suspend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, one cycle per command |
| cmd_op_i | input | 4 | Command code |
| cmd_block_i | input | $clog2(NUM_BLOCKS) | Target block of a program or erase |
| block_lock_i | input | NUM_BLOCKS | Lock bit for each block |
| supply_ok_i | input | 1 | Programming supply within range |
| verify_pass_i | input | 1 | Verify result of the current step |
| status_o | output | 8 | Status register |

## Verification
The assertions assume at most one command per cycle. `cmd_op_i` is treated as meaningful only while `cmd_valid_i` is high, and `cmd_block_i` always indexes an existing block. The bench keeps to these assumptions: each command is a single-cycle strobe driven on the falling edge, and only block indices below NUM_BLOCKS are used. The supply and verify inputs are changed on falling edges at chosen busy cycles, which places acceptance and verify sampling on known edges.

// File: rtl/flash_wsm_pkg.sv
package flash_wsm_pkg;

  typedef enum logic [3:0] {
    CMD_NOP        = 4'd0,
    CMD_PROGRAM    = 4'd1,
    CMD_ERASE      = 4'd2,
    CMD_ERASE_SUSP = 4'd3,
    CMD_ERASE_RES  = 4'd4,
    CMD_PROG_SUSP  = 4'd5,
    CMD_PROG_RES   = 4'd6,
    CMD_CLEAR      = 4'd7,
    CMD_SEQ_ERR    = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_ERASE,
    ST_PROG_SUSP,
    ST_ERASE_SUSP
  } state_e;

  typedef struct packed {
    logic erase_err;
    logic prog_err;
    logic supply_low;
    logic lock_viol;
  } err_flags_t;

endpackage

// File: rtl/flash_wsm_timer.sv
module flash_wsm_timer #(
  parameter int PROG_CYCLES  = 6,
  parameter int PULSE_CYCLES = 4,
  parameter int MAX_PULSES   = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic load_i,
  input  logic load_erase_i,
  input  logic run_i,
  input  logic reload_i,
  output logic cycle_last_o,
  output logic pulse_last_o
);
  localparam int MaxCyc = (PROG_CYCLES > PULSE_CYCLES) ? PROG_CYCLES : PULSE_CYCLES;
  localparam int CW = $clog2(MaxCyc + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);

  logic [CW-1:0] cnt_q;
  logic [PW-1:0] pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= '0;
    end else if (load_i) begin
      cnt_q   <= load_erase_i ? CW'(PULSE_CYCLES) : CW'(PROG_CYCLES);
      pulse_q <= PW'(1);
    end else if (reload_i) begin
      cnt_q   <= CW'(PULSE_CYCLES);
      pulse_q <= pulse_q + PW'(1);
    end else if (run_i) begin
      cnt_q   <= cnt_q - CW'(1);
    end
  end

  assign cycle_last_o = (cnt_q == CW'(1));
  assign pulse_last_o = (pulse_q == PW'(MAX_PULSES));

  // remaining time never runs out while an operation is live
  assert_cnt_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> cnt_q != '0);

  assert_pulse_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (pulse_q >= PW'(1) && pulse_q <= PW'(MAX_PULSES)));

  assert_no_reload_at_max_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |-> !pulse_last_o);

endmodule

// File: rtl/flash_wsm_flags.sv
module flash_wsm_flags
  import flash_wsm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  err_flags_t set_i,
  input  logic       clear_i,
  output err_flags_t flags_o
);
  err_flags_t flags_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (clear_i ? err_flags_t'('0) : flags_q) | set_i;
  end

  assign flags_o = flags_q;

  for (genvar i = 0; i < 4; i++) begin : g_sticky
    assert_flag_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flags_q[i] && !clear_i) |=> flags_q[i]);
  end

  assert_clear_empties_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && set_i == '0) |=> flags_q == '0);

endmodule

// File: rtl/flash_wsm_ctrl.sv
module flash_wsm_ctrl
  import flash_wsm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_op_i,
  input  logic       lock_hit_i,
  input  logic       supply_ok_i,
  input  logic       verify_pass_i,
  input  logic       cycle_last_i,
  input  logic       pulse_last_i,
  output state_e     state_o,
  output logic       load_o,
  output logic       load_erase_o,
  output logic       run_o,
  output logic       reload_o,
  output err_flags_t set_o,
  output logic       clear_o
);
  state_e state_q, state_d;
  cmd_e   cmd;

  assign cmd = cmd_valid_i ? cmd_e'(cmd_op_i) : CMD_NOP;

  always_comb begin
    state_d      = state_q;
    load_o       = 1'b0;
    load_erase_o = 1'b0;
    run_o        = 1'b0;
    reload_o     = 1'b0;
    set_o        = '0;
    clear_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd == CMD_PROGRAM || cmd == CMD_ERASE) begin
          if (lock_hit_i)        set_o.lock_viol  = 1'b1;
          else if (!supply_ok_i) set_o.supply_low = 1'b1;
          else begin
            load_o       = 1'b1;
            load_erase_o = (cmd == CMD_ERASE);
            state_d      = (cmd == CMD_ERASE) ? ST_ERASE : ST_PROG;
          end
        end else if (cmd == CMD_CLEAR) begin
          clear_o = 1'b1;
        end else if (cmd == CMD_SEQ_ERR) begin
          set_o.erase_err = 1'b1;
          set_o.prog_err  = 1'b1;
        end
      end
      ST_PROG: begin
        // a suspend wins over a finishing cycle
        if (cmd == CMD_PROG_SUSP) state_d = ST_PROG_SUSP;
        else if (cycle_last_i) begin
          state_d = ST_IDLE;
          if (!supply_ok_i)        set_o.supply_low = 1'b1;
          else if (!verify_pass_i) set_o.prog_err   = 1'b1;
        end else run_o = 1'b1;
      end
      ST_ERASE: begin
        if (cmd == CMD_ERASE_SUSP) state_d = ST_ERASE_SUSP;
        else if (cycle_last_i) begin
          if (!supply_ok_i) begin
            set_o.supply_low = 1'b1;
            state_d          = ST_IDLE;
          end else if (verify_pass_i) begin
            state_d = ST_IDLE;
          end else if (pulse_last_i) begin
            set_o.erase_err = 1'b1;
            state_d         = ST_IDLE;
          end else reload_o = 1'b1;
        end else run_o = 1'b1;
      end
      ST_PROG_SUSP: begin
        if (cmd == CMD_PROG_RES)   state_d = ST_PROG;
        else if (cmd == CMD_CLEAR) clear_o = 1'b1;
      end
      ST_ERASE_SUSP: begin
        if (cmd == CMD_ERASE_RES)  state_d = ST_ERASE;
        else if (cmd == CMD_CLEAR) clear_o = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_erase_susp_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERASE_SUSP && !(cmd_valid_i && cmd_op_i == CMD_ERASE_RES))
    |=> state_q == ST_ERASE_SUSP);

  assert_prog_susp_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG_SUSP && !(cmd_valid_i && cmd_op_i == CMD_PROG_RES))
    |=> state_q == ST_PROG_SUSP);

  assert_lock_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cmd_valid_i && lock_hit_i &&
     (cmd_op_i == CMD_PROGRAM || cmd_op_i == CMD_ERASE)) |=> state_q == ST_IDLE);

  assert_supply_abort_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cmd_valid_i && !supply_ok_i &&
     (cmd_op_i == CMD_PROGRAM || cmd_op_i == CMD_ERASE)) |=> state_q == ST_IDLE);

  assert_busy_ignores_start_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG && !cycle_last_i && !(cmd_valid_i && cmd_op_i == CMD_PROG_SUSP))
    |=> state_q == ST_PROG);

endmodule

// File: rtl/flash_wsm_status.sv
module flash_wsm_status
  import flash_wsm_pkg::*;
#(
  parameter int NUM_BLOCKS   = 8,
  parameter int PROG_CYCLES  = 6,
  parameter int PULSE_CYCLES = 4,
  parameter int MAX_PULSES   = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cmd_valid_i,
  input  logic [3:0]                    cmd_op_i,
  input  logic [$clog2(NUM_BLOCKS)-1:0] cmd_block_i,
  input  logic [NUM_BLOCKS-1:0]         block_lock_i,
  input  logic                          supply_ok_i,
  input  logic                          verify_pass_i,
  output logic [7:0]                    status_o
);
  state_e     state;
  err_flags_t set, flags;
  logic       load, load_erase, run, reload, clear;
  logic       cycle_last, pulse_last, active;

  flash_wsm_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .lock_hit_i   (block_lock_i[cmd_block_i]),
    .supply_ok_i  (supply_ok_i),
    .verify_pass_i(verify_pass_i),
    .cycle_last_i (cycle_last),
    .pulse_last_i (pulse_last),
    .state_o      (state),
    .load_o       (load),
    .load_erase_o (load_erase),
    .run_o        (run),
    .reload_o     (reload),
    .set_o        (set),
    .clear_o      (clear)
  );

  assign active = (state != ST_IDLE);

  flash_wsm_timer #(
    .PROG_CYCLES (PROG_CYCLES),
    .PULSE_CYCLES(PULSE_CYCLES),
    .MAX_PULSES  (MAX_PULSES)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .load_i      (load),
    .load_erase_i(load_erase),
    .run_i       (run),
    .reload_i    (reload),
    .cycle_last_o(cycle_last),
    .pulse_last_o(pulse_last)
  );

  flash_wsm_flags u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set),
    .clear_i(clear),
    .flags_o(flags)
  );

  assign status_o = {
    !(state == ST_PROG || state == ST_ERASE),
    state == ST_ERASE_SUSP,
    flags.erase_err,
    flags.prog_err,
    flags.supply_low,
    state == ST_PROG_SUSP,
    flags.lock_viol,
    1'b0
  };

  assert_bit0_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] == 1'b0);

  assert_seq_err_code_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[7] && !status_o[6] && !status_o[2] && cmd_valid_i && cmd_op_i == CMD_SEQ_ERR)
    |=> (status_o[7] && status_o[5] && status_o[4]));

  assert_susp_ready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6] || status_o[2]) |-> status_o[7]);

endmodule

// File: tb/flash_wsm_status_tb_top.sv
module flash_wsm_status_tb_top;
  localparam int NB    = 8;
  localparam int PROG  = 6;
  localparam int PULSE = 4;
  localparam int MAXP  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_op = 4'd0;
  logic [2:0] cmd_block = 3'd0;
  logic [7:0] block_lock = 8'h00;
  logic       supply_ok = 1'b1;
  logic       verify_pass = 1'b1;
  logic [7:0] status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  flash_wsm_status #(
    .NUM_BLOCKS(NB), .PROG_CYCLES(PROG), .PULSE_CYCLES(PULSE), .MAX_PULSES(MAXP)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .cmd_block_i(cmd_block), .block_lock_i(block_lock), .supply_ok_i(supply_ok),
    .verify_pass_i(verify_pass), .status_o(status)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, accepted at the next rising edge
  task automatic issue(input logic [3:0] op, input logic [2:0] blk);
    cmd_valid = 1'b1; cmd_op = op; cmd_block = blk;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 4'd0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!status[7] && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    check("R1 reset status", status, 8'h80);
    check("R2 reserved bit", status[0], 0);
  endtask

  task automatic t_program();
    int n;
    verify_pass = 1'b1;
    issue(4'd1, 3'd0);
    check("R3 busy after accept", status[7], 0);
    wait_ready(n);
    check("R3 program busy cycles", n, PROG);
    check("R3 program pass status", status, 8'h80);
    verify_pass = 1'b0;
    issue(4'd1, 3'd1);
    wait_ready(n);
    check("R4 fail busy cycles", n, PROG);
    check("R4 program error", status, 8'h90);
    verify_pass = 1'b1;
    issue(4'd1, 3'd1);
    wait_ready(n);
    check("R11 error kept over new op", status, 8'h90);
    issue(4'd7, 3'd0);
    check("R11 clear status", status, 8'h80);
  endtask

  task automatic t_erase();
    int n;
    verify_pass = 1'b1;
    issue(4'd2, 3'd4);
    wait_ready(n);
    check("R5 erase one pulse", n, PULSE);
    check("R5 erase pass status", status, 8'h80);
    verify_pass = 1'b0;
    issue(4'd2, 3'd4);
    n = 0;
    while (!status[7] && n < 2000) begin
      n++;
      if (n == 2 * PULSE + 1) verify_pass = 1'b1;
      @(negedge clk);
    end
    check("R5 erase third pulse", n, 3 * PULSE);
    check("R5 erase third status", status, 8'h80);
    verify_pass = 1'b0;
    issue(4'd2, 3'd5);
    wait_ready(n);
    check("R5 erase max pulses", n, MAXP * PULSE);
    check("R5 erase error", status, 8'hA0);
    issue(4'd7, 3'd0);
    check("R11 clear after erase", status, 8'h80);
  endtask

  task automatic t_supply();
    int n;
    verify_pass = 1'b1;
    supply_ok = 1'b0;
    issue(4'd1, 3'd0);
    check("R6 supply low at accept", status, 8'h88);
    supply_ok = 1'b1;
    issue(4'd7, 3'd0);
    issue(4'd1, 3'd0);
    supply_ok = 1'b0;
    wait_ready(n);
    check("R6 supply low at verify cycles", n, PROG);
    check("R6 supply low at verify", status, 8'h88);
    supply_ok = 1'b1;
    issue(4'd7, 3'd0);
    issue(4'd1, 3'd0);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    wait_ready(n);
    check("R6 mid-busy dip cycles", n, PROG - 1);
    check("R6 mid-busy dip ignored", status, 8'h80);
  endtask

  task automatic t_lock();
    int n;
    block_lock = 8'h08;
    supply_ok = 1'b0;
    issue(4'd1, 3'd3);
    check("R7 locked program", status, 8'h82);
    issue(4'd7, 3'd0);
    supply_ok = 1'b1;
    issue(4'd2, 3'd3);
    check("R7 locked erase", status, 8'h82);
    issue(4'd7, 3'd0);
    issue(4'd1, 3'd2);
    check("R7 unlocked neighbour runs", status[7], 0);
    wait_ready(n);
    check("R7 unlocked neighbour done", status, 8'h80);
    block_lock = 8'h00;
  endtask

  task automatic t_erase_suspend();
    int n;
    verify_pass = 1'b0;
    issue(4'd2, 3'd0);
    @(negedge clk);
    @(negedge clk);
    issue(4'd3, 3'd0);
    check("R8 erase suspended", status, 8'hC0);
    repeat (5) @(negedge clk);
    check("R8 suspend held", status, 8'hC0);
    issue(4'd6, 3'd0);
    check("R12 wrong resume ignored", status, 8'hC0);
    issue(4'd1, 3'd0);
    check("R12 program in suspend ignored", status, 8'hC0);
    issue(4'd4, 3'd0);
    wait_ready(n);
    check("R8 remaining erase time", n, MAXP * PULSE - 2);
    check("R8 erase end status", status, 8'hA0);
    issue(4'd7, 3'd0);
  endtask

  task automatic t_prog_suspend();
    int n;
    verify_pass = 1'b0;
    issue(4'd1, 3'd0);
    wait_ready(n);
    verify_pass = 1'b1;
    issue(4'd1, 3'd0);
    @(negedge clk);
    @(negedge clk);
    issue(4'd5, 3'd0);
    check("R9 program suspended", status, 8'h94);
    issue(4'd4, 3'd0);
    check("R12 erase resume ignored", status, 8'h94);
    issue(4'd7, 3'd0);
    check("R11 clear while suspended", status, 8'h84);
    issue(4'd6, 3'd0);
    wait_ready(n);
    check("R9 remaining program time", n, PROG - 2);
    check("R9 program end status", status, 8'h80);
  endtask

  task automatic t_seq_err();
    int n;
    verify_pass = 1'b1;
    issue(4'd8, 3'd0);
    check("R10 sequence error", status, 8'hB0);
    issue(4'd1, 3'd0);
    issue(4'd7, 3'd0);
    wait_ready(n);
    check("R11 clear while busy ignored", status, 8'hB0);
    issue(4'd7, 3'd0);
    check("R11 clear after seq error", status, 8'h80);
  endtask

  task automatic t_ignored();
    int n;
    verify_pass = 1'b1;
    issue(4'd1, 3'd0);
    issue(4'd2, 3'd0);
    issue(4'd3, 3'd0);
    check("R12 busy ignores erase and suspend", status, 8'h00);
    wait_ready(n);
    check("R12 busy time unchanged", n + 2, PROG);
    issue(4'd6, 3'd0);
    check("R12 resume while idle", status, 8'h80);
    issue(4'd3, 3'd0);
    check("R12 suspend while idle", status, 8'h80);
    check("R2 reserved bit at end", status[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_supply();
    t_lock();
    t_erase_suspend();
    t_prog_suspend();
    t_seq_err();
    t_ignored();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule